// File: doc/BRIEF.md
# Programmable Odd/Even Clock Divider Stage

This block derives a slower clock from an input clock. The ratio comes from two phase lengths: the number of input cycles the output spends high, and the number it spends low. Their sum is the division ratio. An odd ratio cannot be split evenly on rising edges alone. For that case a half-cycle option retimes the end of the high phase on the falling input edge. The high phase then lasts half a cycle longer and the low phase half a cycle shorter, which gives a 50% duty cycle. A bypass option sends the input clock straight to the output for a ratio of one.

Software writes a single 32-bit setting word. A write with the hold flag set is only stored and changes nothing at the output. A write with the hold flag clear is applied at once and restarts the phase counters. Each applied write drops the `locked` indication for a fixed settle interval. Software waits for `locked` to return before it relies on the new clock. A zero phase length with bypass clear is treated as one, so the output can never stick.

Top module: `clkdiv_stage`

## Requirements
- R1: Setting word fields: low length in bits [5:0], high length in bits [11:6], half-cycle select in bit 12, bypass in bit 13, hold in bit 14. Every write stores bits [14:0] into `cfg_q` on the next cycle, and `cfg_q` bits [31:15] read 0.
- R2: With bypass clear and half-cycle select 0, all output transitions happen on rising input edges. The output is high for `high` input cycles, then low for `low` input cycles, so the period is low+high.
- R3: With half-cycle select 1, the output stays high half an input cycle longer and is low half an input cycle less. Encoding an odd ratio N as low=N/2+1, high=N/2 (integer division) therefore gives N/2 cycles in each phase.
- R4: With bypass set, `clk_out` follows `clk_in`, whatever the phase lengths are.
- R5: A write with hold = 1 leaves the output waveform and `locked` unchanged.
- R6: A write with hold = 0 applies its own fields. The output restarts in the high phase, and `locked` reads 0 from the next cycle.
- R7: After an applied write, `locked` stays 0 for exactly 16 input cycles and then returns to 1. Another applied write during that window restarts the count.
- R8: With bypass clear, a low or high length of 0 behaves as a length of 1.
- R9: After reset, `locked` is 1, `cfg_q` reads 0x41, and the output divides by 2 (one cycle high, one low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Setting-word write strobe |
| wr_data | input | 32 | Setting word |
| cfg_q | output | 32 | Last written setting word (reserved bits zero) |
| locked | output | 1 | 1 when no reprogramming is settling |
| clk_out | output | 1 | Divided clock |

## Verification
The hardest case to reach is the half-cycle stretch. It moves an output edge onto the falling input edge, and a bench that samples once per input cycle cannot see it. The bench therefore samples `clk_out` a quarter period after every input edge, both rising and falling. It measures high and low phase lengths in half-cycle units, and it sweeps every ratio from 1 to 24, every low/high pair up to 4 with both half-cycle settings, and the largest lengths. A second case that is hard to reach is a restart of the settle window. The bench produces it by issuing a second applied write five cycles into the first window.

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
  parameter int CW = 6,
  parameter int RW = 32,
  parameter int SETTLE = 16,
  parameter logic [CW-1:0] RST_LOW = CW'(1),
  parameter logic [CW-1:0] RST_HIGH = CW'(1)
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_data,
  output logic [RW-1:0] cfg_q,
  output logic          locked,
  output logic          clk_out
);
  localparam int FW = 2*CW + 3;
  localparam int HALF_BIT = 2*CW;
  localparam int BYP_BIT = 2*CW + 1;
  localparam int HOLD_BIT = 2*CW + 2;
  localparam int SW = $clog2(SETTLE + 1);

  logic [FW-1:0] held;
  logic [CW-1:0] act_lo, act_hi, cnt, len;
  logic          act_half, act_byp, ph_hi, ph_neg;
  logic [SW-1:0] settle;
  logic          apply;
  logic [CW-1:0] new_lo, new_hi;

  assign apply  = wr_en & ~wr_data[HOLD_BIT];
  assign new_lo = (wr_data[CW-1:0] == '0) ? CW'(1) : wr_data[CW-1:0];
  assign new_hi = (wr_data[2*CW-1:CW] == '0) ? CW'(1) : wr_data[2*CW-1:CW];
  assign len    = ph_hi ? act_hi : act_lo;
  assign cfg_q  = {{(RW-FW){1'b0}}, held};
  assign locked = (settle == '0);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      held <= {3'b000, RST_HIGH, RST_LOW};
    end else if (wr_en) begin
      held <= wr_data[FW-1:0];
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      act_lo   <= RST_LOW;
      act_hi   <= RST_HIGH;
      act_half <= 1'b0;
      act_byp  <= 1'b0;
    end else if (apply) begin
      act_lo   <= new_lo;
      act_hi   <= new_hi;
      act_half <= wr_data[HALF_BIT];
      act_byp  <= wr_data[BYP_BIT];
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      settle <= '0;
    end else if (apply) begin
      settle <= SW'(SETTLE);
    end else if (settle != '0) begin
      settle <= settle - SW'(1);
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      ph_hi <= 1'b1;
      cnt   <= '0;
    end else if (apply) begin
      ph_hi <= 1'b1;
      cnt   <= '0;
    end else if (cnt == len - CW'(1)) begin
      ph_hi <= ~ph_hi;
      cnt   <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      ph_neg <= 1'b1;
    end else begin
      ph_neg <= ph_hi;
    end
  end

  assign clk_out = act_byp ? clk_in : (act_half ? (ph_hi | ph_neg) : ph_hi);
endmodule

module clkdiv_stage_chk #(
  parameter int CW = 6,
  parameter int RW = 32,
  parameter int SETTLE = 16
) (
  input logic          clk_in,
  input logic          rst_n,
  input logic          wr_en,
  input logic [RW-1:0] wr_data,
  input logic [RW-1:0] cfg_q,
  input logic          locked
);
  localparam int FW = 2*CW + 3;
  localparam int HOLD_BIT = 2*CW + 2;

  int since;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      since <= SETTLE;
    end else if (wr_en && !wr_data[HOLD_BIT]) begin
      since <= 0;
    end else if (since < SETTLE) begin
      since <= since + 1;
    end
  end

  assert_readback_R1: assert property (@(posedge clk_in) disable iff (!rst_n)
    wr_en |=> cfg_q == {{(RW-FW){1'b0}}, $past(wr_data[FW-1:0])});

  assert_hold_keeps_lock_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
    (wr_en && wr_data[HOLD_BIT] && locked) |=> locked);

  assert_lock_drop_R6: assert property (@(posedge clk_in) disable iff (!rst_n)
    (wr_en && !wr_data[HOLD_BIT]) |=> !locked);

  assert_settle_window_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
    locked == (since >= SETTLE));
endmodule

bind clkdiv_stage clkdiv_stage_chk #(.CW(CW), .RW(RW), .SETTLE(SETTLE)) u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .cfg_q(cfg_q), .locked(locked)
);

// File: tb/sim_clkdiv_stage.sv
`timescale 1ns/1ps
module sim_clkdiv_stage;
  localparam int CLK_PERIOD = 20;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int QTR = CLK_PERIOD / 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] cfg_q;
  logic        locked;
  logic        clk_out;

  int checks = 0;
  int failures = 0;

  clkdiv_stage u0 (
    .clk_in(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_q(cfg_q), .locked(locked), .clk_out(clk_out)
  );

  always #(HALF) clk = ~clk;

  function automatic logic [31:0] word(int lo, int hi, int e, int b, int h);
    return 32'(lo) | (32'(hi) << 6) | (32'(e) << 12) | (32'(b) << 13) | (32'(h) << 14);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 32'hFFFF_FFFF;
  endtask

  task automatic wait_lock();
    for (int i = 0; i < 100 && !locked; i++) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int lo);
    bit prev, cur;
    int g;
    hi = 0; lo = 0;
    @(posedge clk);
    #(QTR);
    prev = clk_out;
    g = 0;
    do begin #(HALF); cur = clk_out; g++; if (prev == 1'b0 && cur == 1'b1) break; prev = cur; end while (g < 1000);
    while (cur == 1'b1 && hi < 1000) begin hi++; #(HALF); cur = clk_out; end
    while (cur == 1'b0 && lo < 1000) begin lo++; #(HALF); cur = clk_out; end
  endtask

  task automatic run_cfg(input int lo, input int hi, input int e, input int b, input string req);
    int mh, ml, el, eh, xh, xl;
    logic [31:0] v;
    v = word(lo, hi, e, b, 0);
    wr(v);
    chk(cfg_q == v, "R1 readback", int'(cfg_q), int'(v));
    wait_lock();
    measure(mh, ml);
    if (b != 0) begin xh = 1; xl = 1; end
    else begin
      eh = (hi == 0) ? 1 : hi;
      el = (lo == 0) ? 1 : lo;
      xh = 2*eh + e;
      xl = 2*el - e;
    end
    chk(mh == xh, {req, " high half-cycles"}, mh, xh);
    chk(ml == xl, {req, " low half-cycles"}, ml, xl);
  endtask

  initial begin
    int mh, ml, n;
    wr_data = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(locked == 1'b1, "R9 locked after reset", locked, 1);
    chk(cfg_q == 32'h41, "R9 readback after reset", int'(cfg_q), 32'h41);
    measure(mh, ml);
    chk(mh == 2 && ml == 2, "R9 reset ratio 2", mh * 100 + ml, 202);

    for (int r = 1; r <= 24; r++) begin
      if (r == 1) run_cfg(0, 0, 0, 1, "R4 bypass");
      else if (r % 2 == 0) run_cfg(r/2, r/2, 0, 0, "R2 even ratio");
      else run_cfg(r/2 + 1, r/2, 1, 0, "R3 odd ratio");
    end

    for (int e = 0; e < 2; e++)
      for (int lo = 1; lo <= 4; lo++)
        for (int hi = 1; hi <= 4; hi++)
          run_cfg(lo, hi, e, 0, (e != 0) ? "R3 half-cycle pair" : "R2 phase pair");

    run_cfg(63, 63, 0, 0, "R2 max lengths");
    run_cfg(5, 2, 0, 1, "R4 bypass ignores lengths");
    run_cfg(0, 0, 0, 0, "R8 both zero");
    run_cfg(0, 3, 0, 0, "R8 low zero");
    run_cfg(3, 0, 1, 0, "R8 high zero half-cycle");

    run_cfg(2, 2, 0, 0, "R6 apply before hold");
    wr(word(5, 5, 0, 0, 1) | 32'hFFFF_8000);
    chk(locked == 1'b1, "R5 hold keeps locked", locked, 1);
    chk(cfg_q == word(5, 5, 0, 0, 1), "R1 reserved bits read zero", int'(cfg_q), int'(word(5, 5, 0, 0, 1)));
    measure(mh, ml);
    chk(mh == 4 && ml == 4, "R5 hold keeps waveform", mh * 100 + ml, 404);

    wr(word(3, 3, 0, 0, 0));
    chk(locked == 1'b0, "R6 locked drops", locked, 0);
    n = 0;
    while (!locked && n < 100) begin n++; @(negedge clk); end
    chk(n == 16, "R7 settle length", n, 16);
    measure(mh, ml);
    chk(mh == 6 && ml == 6, "R6 applied word", mh * 100 + ml, 606);

    wr(word(2, 2, 0, 0, 0));
    repeat (5) @(negedge clk);
    wr(word(4, 4, 0, 0, 0));
    n = 0;
    while (!locked && n < 100) begin n++; @(negedge clk); end
    chk(n == 16, "R7 settle restart", n, 16);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule